// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block produces the drive waveforms for a linear CCD sensor from a fast system clock. When a line is requested, it first stops the pixel shift clock. It then raises the charge-transfer gate for a programmed time and waits a programmed settle time. Next it runs one full line of shift-clock pulses. That line has a fixed group of leading dummy pixels, the effective pixels and a fixed group of trailing dummy pixels. By default this is 28 + 5000 + 6 = 5034 pulses. With each pulse the block gives the position of the pixel in the line and a tag that says whether the sample is a dummy, an optical-black reference or an effective pixel. A downstream capture path uses these to sort its samples.

Every width and spacing is a count of system clock cycles, taken from configuration inputs. Each count is raised to a safe minimum when it is programmed too low. A two-bit mode input selects how the reset / sample-and-hold pin behaves:

- In the two internal-reset modes the pin is held static, low or high.
- In external-reset mode the pin carries a short low pulse in every pixel period, placed a programmed delay after the shift-clock rising edge. A separate select output tells the sensor which mode is in use.

A start request that arrives during a line is remembered and starts the next line as soon as the current one ends. A running line is never shortened.

Top module: `ccd_line_timer`

## Requirements
- R1: After a start, exactly LEAD+EFF+TRAIL shift-clock pulses are produced (5034 at default parameters), and `pix_idx` takes the values 0, 1, 2, ... in the cycle of each successive rising edge.
- R2: `pix_cls` changes in the cycle of each shift-clock rising edge. It encodes 2'd1 (optical black) for positions 7 to 14 of the leading group, counted from 1. It encodes 2'd0 (dummy) for the rest of the leading group and for the trailing group, and 2'd2 (effective) for the EFF pixels in between.
- R3: `xfer_gate` stays high for exactly the effective gate count of cycles, and `sck` is low during all of that time.
- R4: `xfer_gate` rises the effective pre-gate count of cycles after the cycle in which the start is registered. Before any gate rise, `sck` has been low for at least that count.
- R5: The first shift-clock rising edge of a line comes exactly the effective post-gate count of cycles after `xfer_gate` falls.
- R6: Each shift-clock pulse is high for the effective high count. Between pulses of one line it is low for the effective low count.
- R7: Programmed counts are raised to these minima (defaults at 100 MHz): high 4, low 4, gate 80, pre-gate 10, post-gate 80, reset-low 3, reset-offset 6.
- R8: With `mode[1]` = 1 (external reset), `rs_sel` is 1. In each pixel period `rs_sh` goes low the effective offset count of cycles after the shift-clock rising edge and stays low for the effective reset-low count, unless the next rising edge comes first. At every rising edge it is high.
- R9: With `mode` = 2'd0, `rs_sel` and `rs_sh` are both held at 0. With `mode` = 2'd1, `rs_sel` is 0 and `rs_sh` is held at 1, with no toggling during a line.
- R10: A start that arrives while a line is running is held. It starts one further complete line after the current line ends, and each line still has the full pulse count.
- R11: `line_done` is high for exactly one cycle. That cycle comes the effective low count of cycles after the last shift-clock falling edge.
- R12: During and right after reset, `sck`, `xfer_gate`, `pix_valid` and `line_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Line request strobe |
| mode | input | 2 | 0: internal reset, no S/H; 1: internal reset with S/H; 2/3: external reset |
| cfg_sck_hi | input | CNT_W | Shift-clock high cycles |
| cfg_sck_lo | input | CNT_W | Shift-clock low cycles |
| cfg_gate_w | input | CNT_W | Transfer gate high cycles |
| cfg_pre | input | CNT_W | Cycles from start to gate rise |
| cfg_post | input | CNT_W | Cycles from gate fall to first shift edge |
| cfg_rs_lo | input | CNT_W | External reset low cycles |
| cfg_rs_ofs | input | CNT_W | Cycles from shift rise to reset fall |
| sck | output | 1 | Pixel shift clock |
| xfer_gate | output | 1 | Charge transfer gate pulse |
| rs_sel | output | 1 | Reset source select, 1 = external |
| rs_sh | output | 1 | Reset pulse or static S/H level |
| pix_valid | output | 1 | High while the line is being shifted |
| pix_idx | output | IDX_W | Position of the current pixel in the line |
| pix_cls | output | 2 | Pixel class tag |
| line_done | output | 1 | One-cycle end-of-line strobe |

## Verification
On every cycle the embedded properties check the following relations:
- the gate width, and that the shift clock is quiet under the gate;
- the minimum spacing on both sides of the gate;
- the high and low widths of each shift pulse;
- that the reset pulse is released before each shift edge;
- that the end-of-line strobe is a single cycle.

Other behaviour only the directed scenarios can show. This covers the total pulse count and the order of index and class tags over a whole line, and the exact start-to-gate latency. It also covers clamping of values below the minimum, the static pin levels in the internal modes, and that a start request arriving mid-line yields a second full line.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic [1:0] {
    PIX_DUMMY  = 2'd0,
    PIX_BLACK  = 2'd1,
    PIX_ACTIVE = 2'd2
  } pix_cls_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_GATE, ST_POST, ST_HI, ST_LO, ST_DONE
  } seq_st_t;

  // Raise a programmed count to its floor.
  function automatic int unsigned clamp_up(input int unsigned v, input int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  // Class of a line position (0-based); black range is given 1-based.
  function automatic pix_cls_t classify(input int unsigned idx, input int unsigned lead,
                                        input int unsigned eff, input int unsigned ob_first,
                                        input int unsigned ob_last);
    if (idx < lead)
      return ((idx + 1 >= ob_first) && (idx + 1 <= ob_last)) ? PIX_BLACK : PIX_DUMMY;
    else if (idx < lead + eff)
      return PIX_ACTIVE;
    else
      return PIX_DUMMY;
  endfunction

endpackage

// File: rtl/ccd_tg_cfg.sv
module ccd_tg_cfg
  import ccd_tg_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MIN_HI  = 4,
  parameter int unsigned MIN_LO  = 4,
  parameter int unsigned MIN_GATE = 80,
  parameter int unsigned MIN_PRE = 10,
  parameter int unsigned MIN_POST = 80,
  parameter int unsigned MIN_RSLO = 3,
  parameter int unsigned MIN_RSOFS = 6
) (
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] gate_i,
  input  logic [CNT_W-1:0] pre_i,
  input  logic [CNT_W-1:0] post_i,
  input  logic [CNT_W-1:0] rslo_i,
  input  logic [CNT_W-1:0] rsofs_i,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] gate_o,
  output logic [CNT_W-1:0] pre_o,
  output logic [CNT_W-1:0] post_o,
  output logic [CNT_W-1:0] rslo_o,
  output logic [CNT_W-1:0] rsofs_o
);
  // R7: every count is floored at its minimum
  assign hi_o    = CNT_W'(clamp_up(32'(hi_i),    MIN_HI));
  assign lo_o    = CNT_W'(clamp_up(32'(lo_i),    MIN_LO));
  assign gate_o  = CNT_W'(clamp_up(32'(gate_i),  MIN_GATE));
  assign pre_o   = CNT_W'(clamp_up(32'(pre_i),   MIN_PRE));
  assign post_o  = CNT_W'(clamp_up(32'(post_i),  MIN_POST));
  assign rslo_o  = CNT_W'(clamp_up(32'(rslo_i),  MIN_RSLO));
  assign rsofs_o = CNT_W'(clamp_up(32'(rsofs_i), MIN_RSOFS));
endmodule

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
  import ccd_tg_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LINE  = 5034,
  parameter int unsigned IDX_W = 13,
  parameter int unsigned PH_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] gate_w_i,
  input  logic [CNT_W-1:0] pre_i,
  input  logic [CNT_W-1:0] post_i,
  output logic             sck_o,
  output logic             gate_o,
  output logic             shifting_o,
  output logic             line_done_o,
  output logic [IDX_W-1:0] pix_o,
  output logic [PH_W-1:0]  ph_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE - 1);

  seq_st_t          st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [IDX_W-1:0] pix, pix_n;
  logic [PH_W-1:0]  ph, ph_n;
  logic             pend, go, enter_hi;

  always_comb begin
    st_n     = st;
    cnt_n    = (cnt != '0) ? cnt - 1'b1 : cnt;
    pix_n    = pix;
    go       = 1'b0;
    enter_hi = 1'b0;
    unique case (st)
      ST_IDLE, ST_DONE: begin
        if (pend || start_i) begin
          st_n = ST_PRE; cnt_n = pre_i - 1'b1; go = 1'b1;
        end else st_n = ST_IDLE;
      end
      ST_PRE:  if (cnt == '0) begin st_n = ST_GATE; cnt_n = gate_w_i - 1'b1; end
      ST_GATE: if (cnt == '0) begin st_n = ST_POST; cnt_n = post_i - 1'b1; end
      ST_POST: if (cnt == '0) begin
        st_n = ST_HI; cnt_n = hi_i - 1'b1; pix_n = '0; enter_hi = 1'b1;
      end
      ST_HI:   if (cnt == '0) begin st_n = ST_LO; cnt_n = lo_i - 1'b1; end
      ST_LO:   if (cnt == '0) begin
        if (pix == LAST) st_n = ST_DONE;
        else begin
          st_n = ST_HI; cnt_n = hi_i - 1'b1; pix_n = pix + 1'b1; enter_hi = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    ph_n = enter_hi ? '0 : ((&ph) ? ph : ph + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; pix <= '0; ph <= '0; pend <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      pix  <= pix_n;
      ph   <= ph_n;
      pend <= (pend || start_i) && !go;   // R10: request held until serviced
    end
  end

  assign sck_o       = (st == ST_HI);
  assign gate_o      = (st == ST_GATE);
  assign shifting_o  = (st == ST_HI) || (st == ST_LO);
  assign line_done_o = (st == ST_DONE);
  assign pix_o       = pix;
  assign ph_o        = ph;

  // Observation counters for the properties
  logic [PH_W-1:0] low_run, since_gate, hi_run, gate_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '1; since_gate <= '1; hi_run <= '0; gate_run <= '0;
    end else begin
      low_run    <= sck_o  ? '0 : ((&low_run) ? low_run : low_run + 1'b1);
      since_gate <= gate_o ? '0 : ((&since_gate) ? since_gate : since_gate + 1'b1);
      hi_run     <= sck_o  ? ((&hi_run) ? hi_run : hi_run + 1'b1) : '0;
      gate_run   <= gate_o ? ((&gate_run) ? gate_run : gate_run + 1'b1) : '0;
    end
  end

  p_gate_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> gate_run == {1'b0, gate_w_i});
  p_gate_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> !sck_o);
  p_pre_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> low_run >= {1'b0, pre_i});
  p_post_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> since_gate >= {1'b0, post_i});
  p_hi_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |-> hi_run == {1'b0, hi_i});
  p_lo_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck_o) && pix_o != '0) |-> low_run == {1'b0, lo_i});
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |=> !line_done_o);
  p_done_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_done_o) |-> ($past(pix_o) == LAST && $past(shifting_o)));
endmodule

// File: rtl/ccd_tg_rst.sv
module ccd_tg_rst #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PH_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             shifting_i,
  input  logic             sck_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic [CNT_W-1:0] rslo_i,
  input  logic [CNT_W-1:0] rsofs_i,
  output logic             rs_sel_o,
  output logic             rs_sh_o
);
  logic            ext;
  logic [PH_W-1:0] win_end;
  logic            in_win;

  assign ext     = mode_i[1];
  assign win_end = {1'b0, rsofs_i} + {1'b0, rslo_i};
  assign in_win  = shifting_i && (ph_i >= {1'b0, rsofs_i}) && (ph_i < win_end);

  // R8 / R9: pulse in external mode, static level otherwise
  assign rs_sel_o = ext;
  assign rs_sh_o  = ext ? !in_win : mode_i[0];

  p_rs_clear_of_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck_i) && ext) |-> rs_sh_o);
  p_rs_static_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext && $stable(mode_i)) |-> $stable(rs_sh_o));
endmodule

// File: rtl/ccd_tg_pix.sv
module ccd_tg_pix
  import ccd_tg_pkg::*;
#(
  parameter int unsigned LEAD     = 28,
  parameter int unsigned EFF      = 5000,
  parameter int unsigned OB_FIRST = 7,
  parameter int unsigned OB_LAST  = 14,
  parameter int unsigned IDX_W    = 13
) (
  input  logic [IDX_W-1:0] cnt_i,
  input  logic             shifting_i,
  output logic [IDX_W-1:0] idx_o,
  output pix_cls_t         cls_o
);
  // R2: tag follows the index register, so both move on the rising edge
  assign idx_o = cnt_i;
  assign cls_o = shifting_i ? classify(32'(cnt_i), LEAD, EFF, OB_FIRST, OB_LAST) : PIX_DUMMY;
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_tg_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LEAD      = 28,
  parameter int unsigned EFF       = 5000,
  parameter int unsigned TRAIL     = 6,
  parameter int unsigned OB_FIRST  = 7,
  parameter int unsigned OB_LAST   = 14,
  parameter int unsigned MIN_HI    = 4,
  parameter int unsigned MIN_LO    = 4,
  parameter int unsigned MIN_GATE  = 80,
  parameter int unsigned MIN_PRE   = 10,
  parameter int unsigned MIN_POST  = 80,
  parameter int unsigned MIN_RSLO  = 3,
  parameter int unsigned MIN_RSOFS = 6,
  localparam int unsigned LINE  = LEAD + EFF + TRAIL,
  localparam int unsigned IDX_W = $clog2(LINE),
  localparam int unsigned PH_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] cfg_sck_hi,
  input  logic [CNT_W-1:0] cfg_sck_lo,
  input  logic [CNT_W-1:0] cfg_gate_w,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_post,
  input  logic [CNT_W-1:0] cfg_rs_lo,
  input  logic [CNT_W-1:0] cfg_rs_ofs,
  output logic             sck,
  output logic             xfer_gate,
  output logic             rs_sel,
  output logic             rs_sh,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_idx,
  output logic [1:0]       pix_cls,
  output logic             line_done
);
  logic [CNT_W-1:0] hi_e, lo_e, gate_e, pre_e, post_e, rslo_e, rsofs_e;
  logic [IDX_W-1:0] pix_cnt;
  logic [PH_W-1:0]  ph;
  logic             shifting;
  pix_cls_t         cls;

  ccd_tg_cfg #(
    .CNT_W(CNT_W), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO), .MIN_GATE(MIN_GATE),
    .MIN_PRE(MIN_PRE), .MIN_POST(MIN_POST), .MIN_RSLO(MIN_RSLO), .MIN_RSOFS(MIN_RSOFS)
  ) u_cfg (
    .hi_i(cfg_sck_hi), .lo_i(cfg_sck_lo), .gate_i(cfg_gate_w), .pre_i(cfg_pre),
    .post_i(cfg_post), .rslo_i(cfg_rs_lo), .rsofs_i(cfg_rs_ofs),
    .hi_o(hi_e), .lo_o(lo_e), .gate_o(gate_e), .pre_o(pre_e),
    .post_o(post_e), .rslo_o(rslo_e), .rsofs_o(rsofs_e)
  );

  ccd_tg_seq #(.CNT_W(CNT_W), .LINE(LINE), .IDX_W(IDX_W), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .hi_i(hi_e), .lo_i(lo_e), .gate_w_i(gate_e), .pre_i(pre_e), .post_i(post_e),
    .sck_o(sck), .gate_o(xfer_gate), .shifting_o(shifting), .line_done_o(line_done),
    .pix_o(pix_cnt), .ph_o(ph)
  );

  ccd_tg_rst #(.CNT_W(CNT_W), .PH_W(PH_W)) u_rst (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .shifting_i(shifting), .sck_i(sck),
    .ph_i(ph), .rslo_i(rslo_e), .rsofs_i(rsofs_e), .rs_sel_o(rs_sel), .rs_sh_o(rs_sh)
  );

  ccd_tg_pix #(
    .LEAD(LEAD), .EFF(EFF), .OB_FIRST(OB_FIRST), .OB_LAST(OB_LAST), .IDX_W(IDX_W)
  ) u_pix (
    .cnt_i(pix_cnt), .shifting_i(shifting), .idx_o(pix_idx), .cls_o(cls)
  );

  assign pix_valid = shifting;
  assign pix_cls   = cls;

  p_tag_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> (pix_valid && pix_cls != 2'd3));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> !sck);
endmodule

// File: tb/ccd_line_timer_test.sv
module ccd_line_timer_test;
  localparam int LEAD = 28, EFF = 40, TRAIL = 6;
  localparam int LINE = LEAD + EFF + TRAIL;
  localparam int IW = $clog2(LINE);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'd2;
  logic [7:0] c_hi = 8'd5, c_lo = 8'd6, c_gate = 8'd90, c_pre = 8'd12, c_post = 8'd85;
  logic [7:0] c_rslo = 8'd4, c_rsofs = 8'd7;
  logic sck, xfer_gate, rs_sel, rs_sh, pix_valid, line_done;
  logic [IW-1:0] pix_idx;
  logic [1:0] pix_cls;

  always #5 clk = ~clk;

  ccd_line_timer #(.LEAD(LEAD), .EFF(EFF), .TRAIL(TRAIL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .cfg_sck_hi(c_hi), .cfg_sck_lo(c_lo), .cfg_gate_w(c_gate), .cfg_pre(c_pre),
    .cfg_post(c_post), .cfg_rs_lo(c_rslo), .cfg_rs_ofs(c_rsofs),
    .sck(sck), .xfer_gate(xfer_gate), .rs_sel(rs_sel), .rs_sh(rs_sh),
    .pix_valid(pix_valid), .pix_idx(pix_idx), .pix_cls(pix_cls), .line_done(line_done)
  );

  int checks = 0, errors = 0, cyc = 0;

  // observation state, sampled on falling edges
  logic p_sck = 0, p_gate = 0, p_rs = 1, p_done = 0;
  int t_rise, t_fall, t_grise, t_gfall, t_rsf, t_done;
  int nrise, ndone, ngate, idx_err, cls_err, nblk, neff, gate_sck, done_dbl;
  int hi_min, hi_max, lo_min, lo_max, post_m, gw_m, done_gap;
  int rso_min, rso_max, rsw_min, rsw_max, rs_edges, nrsf;
  int line_rises [0:3];

  function automatic int exp_cls(input int i);
    if (i >= LEAD + EFF) return 0;
    if (i >= LEAD) return 2;
    if (i >= 6 && i <= 13) return 1;
    return 0;
  endfunction

  task automatic clear_stats();
    t_rise = 0; t_fall = 0; t_grise = 0; t_gfall = 0; t_rsf = 0; t_done = 0;
    nrise = 0; ndone = 0; ngate = 0; idx_err = 0; cls_err = 0; nblk = 0; neff = 0;
    gate_sck = 0; done_dbl = 0; post_m = -1; gw_m = -1; done_gap = -1;
    hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
    rso_min = 9999; rso_max = 0; rsw_min = 9999; rsw_max = 0; rs_edges = 0; nrsf = 0;
    for (int k = 0; k < 4; k++) line_rises[k] = -1;
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (sck && !p_sck) begin
        if (t_fall > t_gfall) begin
          if (cyc - t_fall < lo_min) lo_min = cyc - t_fall;
          if (cyc - t_fall > lo_max) lo_max = cyc - t_fall;
        end else post_m = cyc - t_gfall;
        if (int'(pix_idx) != nrise) idx_err++;
        if (int'(pix_cls) != exp_cls(nrise)) cls_err++;
        if (pix_cls == 2'd1) nblk++;
        if (pix_cls == 2'd2) neff++;
        nrise++;
        t_rise = cyc;
      end
      if (!sck && p_sck) begin
        if (cyc - t_rise < hi_min) hi_min = cyc - t_rise;
        if (cyc - t_rise > hi_max) hi_max = cyc - t_rise;
        t_fall = cyc;
      end
      if (xfer_gate && !p_gate) begin t_grise = cyc; ngate++; end
      if (xfer_gate && sck) gate_sck++;
      if (!xfer_gate && p_gate) begin gw_m = cyc - t_grise; t_gfall = cyc; end
      if (rs_sh != p_rs) rs_edges++;
      if (!rs_sh && p_rs) begin
        t_rsf = cyc; nrsf++;
        if (cyc - t_rise < rso_min) rso_min = cyc - t_rise;
        if (cyc - t_rise > rso_max) rso_max = cyc - t_rise;
      end
      if (rs_sh && !p_rs && t_rsf > 0) begin
        if (cyc - t_rsf < rsw_min) rsw_min = cyc - t_rsf;
        if (cyc - t_rsf > rsw_max) rsw_max = cyc - t_rsf;
      end
      if (line_done) begin
        if (p_done) done_dbl++;
        done_gap = cyc - t_fall;
        if (ndone < 4) line_rises[ndone] = nrise;
        ndone++; nrise = 0; t_done = cyc;
      end
    end
    p_sck = sck; p_gate = xfer_gate; p_rs = rs_sh; p_done = line_done;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(negedge clk) if (cyc > 150000) begin
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  task automatic pulse_start(output int s);
    @(negedge clk); #1; start = 1'b1; s = cyc;
    @(negedge clk); #1; start = 1'b0;
  endtask

  task automatic wait_lines(input int n);
    int guard = 0;
    while (ndone < n && guard < 20000) begin @(negedge clk); #1; guard++; end
    if (ndone < n) chk("R11", "line_done timeout", ndone, n);
    repeat (3) @(negedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk("R12", "sck in reset", int'(sck), 0);
    chk("R12", "gate in reset", int'(xfer_gate), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12", "valid after reset", int'(pix_valid), 0);
    chk("R12", "done after reset", int'(line_done), 0);
  endtask

  task automatic t_normal();
    int s;
    mode = 2'd2; c_hi = 5; c_lo = 6; c_gate = 90; c_pre = 12; c_post = 85; c_rslo = 4; c_rsofs = 7;
    @(negedge clk); #1; clear_stats();
    pulse_start(s);
    wait_lines(1);
    chk("R1", "pulses per line", line_rises[0], LINE);
    chk("R1", "index order errors", idx_err, 0);
    chk("R2", "class tag errors", cls_err, 0);
    chk("R2", "black pixels", nblk, 8);
    chk("R2", "effective pixels", neff, EFF);
    chk("R3", "gate width", gw_m, 90);
    chk("R3", "sck during gate", gate_sck, 0);
    chk("R4", "start to gate", t_grise - s, 13);
    chk("R5", "gate fall to first sck", post_m, 85);
    chk("R6", "high min", hi_min, 5);
    chk("R6", "high max", hi_max, 5);
    chk("R6", "low min", lo_min, 6);
    chk("R6", "low max", lo_max, 6);
    chk("R8", "rs_sel", int'(rs_sel), 1);
    chk("R8", "rs pulses", nrsf, LINE);
    chk("R8", "rs offset min", rso_min, 7);
    chk("R8", "rs offset max", rso_max, 7);
    chk("R8", "rs low min", rsw_min, 4);
    chk("R8", "rs low max", rsw_max, 4);
    chk("R11", "done after last fall", done_gap, 6);
    chk("R11", "done single", done_dbl, 0);
    chk("R11", "done count", ndone, 1);
  endtask

  task automatic t_clamp();
    int s;
    mode = 2'd2; c_hi = 1; c_lo = 20; c_gate = 10; c_pre = 0; c_post = 5; c_rslo = 1; c_rsofs = 0;
    @(negedge clk); #1; clear_stats();
    pulse_start(s);
    wait_lines(1);
    chk("R7", "high clamped", hi_max, 4);
    chk("R7", "low unclamped", lo_max, 20);
    chk("R7", "gate clamped", gw_m, 80);
    chk("R7", "pre clamped", t_grise - s, 11);
    chk("R7", "post clamped", post_m, 80);
    chk("R7", "rs offset clamped", rso_max, 6);
    chk("R7", "rs low clamped", rsw_max, 3);
    chk("R1", "pulses clamped line", line_rises[0], LINE);
  endtask

  task automatic t_internal(input logic [1:0] m);
    int s;
    mode = m; c_hi = 5; c_lo = 6; c_gate = 90; c_pre = 12; c_post = 85; c_rslo = 4; c_rsofs = 7;
    repeat (2) @(negedge clk); #1; clear_stats();
    pulse_start(s);
    wait_lines(1);
    chk("R9", "rs_sel internal", int'(rs_sel), 0);
    chk("R9", "rs_sh level", int'(rs_sh), int'(m[0]));
    chk("R9", "rs_sh toggles", rs_edges, 0);
  endtask

  task automatic t_queue();
    int s, s2, guard;
    mode = 2'd2; c_hi = 5; c_lo = 6; c_gate = 90; c_pre = 12; c_post = 85; c_rslo = 4; c_rsofs = 7;
    @(negedge clk); #1; clear_stats();
    pulse_start(s);
    guard = 0;
    while (nrise < 10 && guard < 5000) begin @(negedge clk); #1; guard++; end
    pulse_start(s2);
    wait_lines(2);
    chk("R10", "first line pulses", line_rises[0], LINE);
    chk("R10", "second line pulses", line_rises[1], LINE);
    chk("R10", "gate pulses", ngate, 2);
    chk("R10", "lines done", ndone, 2);
  endtask

  initial begin
    clear_stats();
    t_reset();
    t_normal();
    t_clamp();
    t_internal(2'd0);
    t_internal(2'd1);
    t_queue();
    finish_run();
  end
endmodule